// File: doc/BRIEF.md
# Exception Entry Vector Unit

When a processor core takes an exception, this unit works out everything that changes at the moment of entry. It returns the program counter of the handler and the return address to save. It says which of the three return-address registers receives that address: the general one, the one for error entries or the one for debug entries. It also returns the updated status and cause words. The core asserts `take` for one cycle. The unit gives the exception kind, the faulting PC, whether the faulting instruction sat in a branch delay slot, whether a TLB fault was a refill miss, the coprocessor number, and the current status, cause and exception-base words.

One clock edge later, every result is held in a register and `done` pulses for one cycle. General exceptions choose between a boot-time base and the programmable base, and then add an offset that depends on the kind. If an exception arrives while one is already in progress, the saved return address and the delay-slot marker are left alone. Non-maskable interrupts and soft resets go to a fixed error vector. Debug entries go to a fixed debug vector.

Top module: `exv_unit`

## Requirements
- R1: While `rst` is high, on the next rising edge `done`, `epc_we`, `errepc_we`, `depc_we` and `enter_debug` go low, and `next_pc`, `save_pc`, `status_out` and `cause_out` go to zero.
- R2: The results of an entry appear on the clock edge that samples `take` high, with `done` high for exactly that cycle. A cycle with `take` low gives `done`, all three write enables and `enter_debug` low.
- R3: For a general exception the handler base is 0xBFC00200 when status bit 22 (BEV) is set, and otherwise `ebase` with bits [9:0] cleared. The default offset added to the base is 0x180.
- R4: Kind 0 (interrupt) uses offset 0x200 when cause bit 23 (IV) is set, and 0x180 when it is clear.
- R5: Kinds 2 and 3 (TLB load, TLB store) use offset 0x000 when `refill` is high and status bit 1 (EXL) is clear, and 0x180 otherwise.
- R6: Kind 30 (cache error) uses offset 0x100 when BEV is set and 0x20000100 when it is clear.
- R7: For a general exception with EXL clear, `epc_we` is set and `save_pc` is `pc`, or `pc`-4 when `in_slot` is high. Cause bit 31 (BD) takes the value of `in_slot`, EXL is set and status bits [4:3] (mode) are cleared to kernel.
- R8: For a general exception with EXL already set, `epc_we` stays low and status and cause bit 31 are returned unchanged except for the code fields.
- R9: The kind encoding is a 5-bit value. For a general exception it is also the code written to cause bits [6:2], with interrupt 0, modify 1, TLB load 2, TLB store 3, address error load 4 and store 5, bus errors 6 and 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15 and cache error 30. Kinds 16 (NMI), 17 (soft reset) and 19 (debug) are the special entries, and they leave cause bits [6:2] unchanged. Cause bits not named in a requirement pass through unchanged.
- R10: Kind 11 writes `cop_num` into cause bits [29:28]. Every other kind leaves those bits unchanged.
- R11: Kinds 16 and 17 set `errepc_we` and save the same slot-corrected PC. They set status bits 2 (ERL) and 22 (BEV), clear the mode bits, and jump to 0xBFC00000. Kind 16 also sets status bit 19, and kind 17 sets status bit 20. When EXL is clear they clear cause bit 31.
- R12: Kind 19 sets `depc_we` and `enter_debug`, saves the slot-corrected PC, clears the mode bits, jumps to 0xBFC00480, and clears cause bit 31 when EXL is clear.
- R13: At most one of `epc_we`, `errepc_we` and `depc_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take | input | 1 | Exception is being taken this cycle |
| kind | input | 5 | Exception kind (see R9) |
| pc | input | 32 | PC of the faulting instruction |
| in_slot | input | 1 | Faulting instruction is in a branch delay slot |
| refill | input | 1 | TLB fault found no matching entry |
| cop_num | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| status_in | input | 32 | Current status word |
| cause_in | input | 32 | Current cause word |
| ebase | input | 32 | Programmable exception base |
| done | output | 1 | Entry results valid this cycle |
| next_pc | output | 32 | Handler address |
| save_pc | output | 32 | Return address to store |
| epc_we | output | 1 | Store `save_pc` in the general return register |
| errepc_we | output | 1 | Store `save_pc` in the error return register |
| depc_we | output | 1 | Store `save_pc` in the debug return register |
| status_out | output | 32 | Updated status word |
| cause_out | output | 32 | Updated cause word |
| enter_debug | output | 1 | Core enters debug mode |

## Verification
Assertions check on every cycle the one-cycle timing of `done` and the write enables, and that the three save targets are mutually exclusive. They also check that a first-level general entry sets EXL, that a nested one never writes the return register, and that the error and debug entries reach their fixed vectors. The vector offsets need the bench's full sweep to show that they are right. So do the choice of base, the cause code and coprocessor field, the delay-slot correction and the pass-through of untouched status and cause bits. The sweep covers every kind against every combination of EXL, BEV, IV, refill and delay slot.

// File: rtl/exv_pkg.sv
package exv_pkg;
  localparam int WORD_W = 32;

  // status word bit positions
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_MODE_L = 3;
  localparam int ST_NMI    = 19;
  localparam int ST_SR     = 20;
  localparam int ST_BEV    = 22;

  // cause word bit positions
  localparam int CA_CODE_L = 2;
  localparam int CA_IV     = 23;
  localparam int CA_CE_L   = 28;
  localparam int CA_BD     = 31;

  // kinds with special handling
  localparam logic [4:0] K_INT   = 5'd0;
  localparam logic [4:0] K_TLBL  = 5'd2;
  localparam logic [4:0] K_TLBS  = 5'd3;
  localparam logic [4:0] K_COPU  = 5'd11;
  localparam logic [4:0] K_NMI   = 5'd16;
  localparam logic [4:0] K_SRST  = 5'd17;
  localparam logic [4:0] K_DEBUG = 5'd19;
  localparam logic [4:0] K_CACHE = 5'd30;

  localparam logic [WORD_W-1:0] OFF_GEN     = 32'h0000_0180;
  localparam logic [WORD_W-1:0] OFF_IRQ_VEC = 32'h0000_0200;
  localparam logic [WORD_W-1:0] OFF_REFILL  = 32'h0000_0000;
  localparam logic [WORD_W-1:0] OFF_CE_BOOT = 32'h0000_0100;
  localparam logic [WORD_W-1:0] OFF_CE_RUN  = 32'h2000_0100;

  typedef enum logic [1:0] {
    PATH_GEN = 2'd0,
    PATH_ERR = 2'd1,
    PATH_DBG = 2'd2
  } entry_path_e;

  typedef struct packed {
    entry_path_e       path;
    logic [WORD_W-1:0] offset;
    logic              is_nmi;
    logic              is_srst;
    logic              is_copu;
  } entry_dec_t;

  function automatic logic kind_is_general(input logic [4:0] k);
    return !(k == K_NMI || k == K_SRST || k == K_DEBUG);
  endfunction
endpackage

// File: rtl/exv_decode.sv
module exv_decode
  import exv_pkg::*;
(
  input  logic [4:0]  kind,
  input  logic        refill,
  input  logic        exl,
  input  logic        bev,
  input  logic        iv,
  output entry_dec_t  dec
);
  always_comb begin
    dec         = '0;
    dec.is_nmi  = (kind == K_NMI);
    dec.is_srst = (kind == K_SRST);
    dec.is_copu = (kind == K_COPU);
    if (dec.is_nmi || dec.is_srst) begin
      dec.path = PATH_ERR;
    end else if (kind == K_DEBUG) begin
      dec.path = PATH_DBG;
    end else begin
      dec.path   = PATH_GEN;
      dec.offset = OFF_GEN;
      if (kind == K_INT && iv)
        dec.offset = OFF_IRQ_VEC;
      if ((kind == K_TLBL || kind == K_TLBS) && refill && !exl)
        dec.offset = OFF_REFILL;
      if (kind == K_CACHE)
        dec.offset = bev ? OFF_CE_BOOT : OFF_CE_RUN;
    end
  end
endmodule

// File: rtl/exv_target.sv
module exv_target
  import exv_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                ALIGN_BITS = 10,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [ADDR_W-1:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] DBG_VEC    = 32'hBFC0_0480
) (
  input  entry_dec_t        dec,
  input  logic              bev,
  input  logic [ADDR_W-1:0] ebase,
  input  logic [ADDR_W-1:0] pc,
  input  logic              in_slot,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] save_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] base_mask;
  logic [ADDR_W-1:0] gen_base;

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign base_mask = '1;
    end else begin : g_align
      assign base_mask = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));
    end
  endgenerate

  assign gen_base = bev ? BOOT_BASE : (ebase & base_mask);
  assign save_pc  = in_slot ? (pc - STEP) : pc;

  always_comb begin
    unique case (dec.path)
      PATH_ERR: next_pc = ERR_VEC;
      PATH_DBG: next_pc = DBG_VEC;
      default:  next_pc = gen_base + ADDR_W'(dec.offset);
    endcase
  end
endmodule

// File: rtl/exv_fields.sv
module exv_fields
  import exv_pkg::*;
(
  input  entry_dec_t        dec,
  input  logic [4:0]        kind,
  input  logic              in_slot,
  input  logic [1:0]        cop_num,
  input  logic [WORD_W-1:0] status_in,
  input  logic [WORD_W-1:0] cause_in,
  output logic [WORD_W-1:0] status_n,
  output logic [WORD_W-1:0] cause_n,
  output logic [2:0]        save_sel,   // {debug, error, general}
  output logic              dbg_n
);
  logic exl;
  assign exl = status_in[ST_EXL];

  always_comb begin
    status_n = status_in;
    cause_n  = cause_in;
    save_sel = 3'b000;
    dbg_n    = 1'b0;
    unique case (dec.path)
      PATH_ERR: begin
        save_sel[1]                 = 1'b1;
        status_n[ST_ERL]            = 1'b1;
        status_n[ST_BEV]            = 1'b1;
        status_n[ST_MODE_L+:2]      = 2'b00;
        if (dec.is_nmi)  status_n[ST_NMI] = 1'b1;
        if (dec.is_srst) status_n[ST_SR]  = 1'b1;
        if (!exl) cause_n[CA_BD]    = 1'b0;
      end
      PATH_DBG: begin
        save_sel[2]                 = 1'b1;
        dbg_n                       = 1'b1;
        status_n[ST_MODE_L+:2]      = 2'b00;
        if (!exl) cause_n[CA_BD]    = 1'b0;
      end
      default: begin
        if (!exl) begin
          save_sel[0]               = 1'b1;
          cause_n[CA_BD]            = in_slot;
          status_n[ST_EXL]          = 1'b1;
          status_n[ST_MODE_L+:2]    = 2'b00;
        end
        cause_n[CA_CODE_L+:5]       = kind;
        if (dec.is_copu)
          cause_n[CA_CE_L+:2]       = cop_num;
      end
    endcase
  end
endmodule

// File: rtl/exv_unit.sv
module exv_unit
  import exv_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                ALIGN_BITS = 10,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [ADDR_W-1:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] DBG_VEC    = 32'hBFC0_0480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [4:0]        kind,
  input  logic [ADDR_W-1:0] pc,
  input  logic              in_slot,
  input  logic              refill,
  input  logic [1:0]        cop_num,
  input  logic [WORD_W-1:0] status_in,
  input  logic [WORD_W-1:0] cause_in,
  input  logic [ADDR_W-1:0] ebase,
  output logic              done,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] save_pc,
  output logic              epc_we,
  output logic              errepc_we,
  output logic              depc_we,
  output logic [WORD_W-1:0] status_out,
  output logic [WORD_W-1:0] cause_out,
  output logic              enter_debug
);
  entry_dec_t        dec;
  logic [ADDR_W-1:0] npc_c, spc_c;
  logic [WORD_W-1:0] st_c, ca_c;
  logic [2:0]        sel_c;
  logic              dbg_c;

  exv_decode u_decode (
    .kind   (kind),
    .refill (refill),
    .exl    (status_in[ST_EXL]),
    .bev    (status_in[ST_BEV]),
    .iv     (cause_in[CA_IV]),
    .dec    (dec)
  );

  exv_target #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .INSN_BYTES(INSN_BYTES),
    .BOOT_BASE(BOOT_BASE), .ERR_VEC(ERR_VEC), .DBG_VEC(DBG_VEC)
  ) u_target (
    .dec     (dec),
    .bev     (status_in[ST_BEV]),
    .ebase   (ebase),
    .pc      (pc),
    .in_slot (in_slot),
    .next_pc (npc_c),
    .save_pc (spc_c)
  );

  exv_fields u_fields (
    .dec       (dec),
    .kind      (kind),
    .in_slot   (in_slot),
    .cop_num   (cop_num),
    .status_in (status_in),
    .cause_in  (cause_in),
    .status_n  (st_c),
    .cause_n   (ca_c),
    .save_sel  (sel_c),
    .dbg_n     (dbg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      epc_we      <= 1'b0;
      errepc_we   <= 1'b0;
      depc_we     <= 1'b0;
      enter_debug <= 1'b0;
      next_pc     <= '0;
      save_pc     <= '0;
      status_out  <= '0;
      cause_out   <= '0;
    end else begin
      done        <= take;
      epc_we      <= take & sel_c[0];
      errepc_we   <= take & sel_c[1];
      depc_we     <= take & sel_c[2];
      enter_debug <= take & dbg_c;
      if (take) begin
        next_pc    <= npc_c;
        save_pc    <= spc_c;
        status_out <= st_c;
        cause_out  <= ca_c;
      end
    end
  end

  // R2: one-cycle result timing
  p_done_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> done);
  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !take |=> !done && !epc_we && !errepc_we && !depc_we && !enter_debug);

  // R13: save targets are exclusive
  p_one_save_target_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({epc_we, errepc_we, depc_we}));

  // R7: first-level general entry raises EXL and clears the mode
  p_first_entry_sets_exl_r7: assert property (@(posedge clk) disable iff (rst)
    take && kind_is_general(kind) && !status_in[ST_EXL]
    |=> epc_we && status_out[ST_EXL] && status_out[ST_MODE_L+:2] == 2'b00);

  // R8: nested general entry never writes the return register
  p_nested_no_epc_r8: assert property (@(posedge clk) disable iff (rst)
    take && kind_is_general(kind) && status_in[ST_EXL] |=> !epc_we);

  // R11: error entries reach the error vector with ERL and BEV set
  p_error_vector_r11: assert property (@(posedge clk) disable iff (rst)
    take && (kind == K_NMI || kind == K_SRST)
    |=> errepc_we && next_pc == ERR_VEC && status_out[ST_ERL] && status_out[ST_BEV]);

  // R12: debug entry
  p_debug_vector_r12: assert property (@(posedge clk) disable iff (rst)
    take && kind == K_DEBUG |=> depc_we && enter_debug && next_pc == DBG_VEC);
endmodule

// File: tb/exv_unit_bench.sv
module exv_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0;
  logic        in_slot = 1'b0;
  logic        refill = 1'b0;
  logic [1:0]  cop_num = '0;
  logic [31:0] status_in = '0;
  logic [31:0] cause_in = '0;
  logic [31:0] ebase = '0;
  logic        done, epc_we, errepc_we, depc_we, enter_debug;
  logic [31:0] next_pc, save_pc, status_out, cause_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  exv_unit u_exv_unit (
    .clk(clk), .rst(rst), .take(take), .kind(kind), .pc(pc),
    .in_slot(in_slot), .refill(refill), .cop_num(cop_num),
    .status_in(status_in), .cause_in(cause_in), .ebase(ebase),
    .done(done), .next_pc(next_pc), .save_pc(save_pc), .epc_we(epc_we),
    .errepc_we(errepc_we), .depc_we(depc_we), .status_out(status_out),
    .cause_out(cause_out), .enter_debug(enter_debug)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (kind=%0d)", req, act, exp, kind);
    end
  endtask

  // expected results, from the requirements
  logic [31:0] e_npc, e_spc, e_st, e_ca;
  logic [3:0]  e_we;  // {debug, depc, errepc, epc}
  string       t_npc, t_path, t_ca;

  task automatic model();
    logic exl, bev, iv, gen;
    logic [31:0] base, off;
    exl = status_in[1]; bev = status_in[22]; iv = cause_in[23];
    gen = !(kind == 5'd16 || kind == 5'd17 || kind == 5'd19);
    e_spc = in_slot ? pc - 32'd4 : pc;
    e_st = status_in; e_ca = cause_in; e_we = 4'b0000;
    t_ca = (gen && kind == 5'd11) ? "R10" : "R9";
    if (gen) begin
      base = bev ? 32'hBFC0_0200 : {ebase[31:10], 10'b0};
      off = 32'h180; t_npc = "R3";
      if (kind == 5'd0) begin t_npc = "R4"; if (iv) off = 32'h200; end
      if (kind == 5'd2 || kind == 5'd3) begin
        t_npc = "R5"; if (refill && !exl) off = 32'h0;
      end
      if (kind == 5'd30) begin
        t_npc = "R6"; off = bev ? 32'h100 : 32'h2000_0100;
      end
      e_npc = base + off;
      t_path = exl ? "R8" : "R7";
      if (!exl) begin
        e_we = 4'b0001; e_st[1] = 1'b1; e_st[4:3] = 2'b00; e_ca[31] = in_slot;
      end
      e_ca[6:2] = kind;
      if (kind == 5'd11) e_ca[29:28] = cop_num;
    end else if (kind != 5'd19) begin
      t_npc = "R11"; t_path = "R11";
      e_npc = 32'hBFC0_0000; e_we = 4'b0010;
      e_st[2] = 1'b1; e_st[22] = 1'b1; e_st[4:3] = 2'b00;
      if (kind == 5'd16) e_st[19] = 1'b1; else e_st[20] = 1'b1;
      if (!exl) e_ca[31] = 1'b0;
    end else begin
      t_npc = "R12"; t_path = "R12";
      e_npc = 32'hBFC0_0480; e_we = 4'b1100;
      e_st[4:3] = 2'b00;
      if (!exl) e_ca[31] = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {28'b0, done, epc_we, errepc_we, depc_we}, 32'h0);
    chk("R1", {31'b0, enter_debug}, 32'h0);
    chk("R1", next_pc | save_pc, 32'h0);
    chk("R1", status_out | cause_out, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      kind      = i[4:0];
      status_in = 32'h1000_FF18 ^ (i << 8);
      status_in[1]  = i[5];
      status_in[22] = i[6];
      in_slot   = i[7];
      refill    = i[8];
      cause_in  = 32'h3000_A5A0 ^ (i << 2) ^ (i[1] ? 32'h8000_0000 : 32'h0);
      cause_in[23] = i[9];
      cop_num   = 2'(i * 3 + 1);
      ebase     = 32'h8123_4567 ^ (i * 32'h0001_0F0F);
      pc        = i[10] ? 32'h0000_0000 + 32'(i[1:0]) * 4 : 32'h0040_0000 + i * 8;
      take      = 1'b1;
      model();
      @(negedge clk);
      take = 1'b0;
      chk("R2", {31'b0, done}, 32'h1);
      chk(t_npc, next_pc, e_npc);
      chk(t_path, save_pc, e_spc);
      chk(t_path, {28'b0, enter_debug, depc_we, errepc_we, epc_we}, {28'b0, e_we});
      chk(t_path, status_out, e_st);
      chk(t_ca, cause_out, e_ca);
      chk("R13", 32'($countones({epc_we, errepc_we, depc_we}) <= 1), 32'h1);
      @(negedge clk);
      chk("R2", {27'b0, done, epc_we, errepc_we, depc_we, enter_debug}, 32'h0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule